// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire Ethernet PHY management bus on its own. A host raises a one-cycle request carrying the operation (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then generates the management clock and shifts the frame onto the data line. For a read it releases the line, checks whether the PHY pulls it low during turnaround, and shifts in 16 result bits.

Each half of the management clock lasts `DIV` system clock cycles. Only one transaction runs at a time. `busy` covers the whole transaction and `done` pulses once at its end. For a read, `rdata` and `ack_ok` are valid in the cycle that `done` is high. The data line is split into an output value, an output enable and an input, so the pad tristate sits outside the block.

Top module: `mdio_master`

## Requirements
- R1: While idle and out of reset, `busy`, `done`, `mdc` and `mdio_oe` are all low. Reset sets `rdata` to 16'hFFFF.
- R2: A request (`req` high) is taken only while `busy` is low, and `busy` is high from the next cycle. A request raised while busy is ignored: the frame in progress is unchanged and no further transaction follows it.
- R3: `mdc` has a period of 2*DIV system cycles, low phase first. The first rising edge comes DIV cycles after the accepting edge.
- R4: Every frame begins with 32 driven ones. Bits go out MSB first, and each bit is stable on `mdio_o` around the `mdc` rising edge.
- R5: A write drives 64 bits in total. After the preamble come start 01, opcode 01, PHY address[4:0], register address[4:0], turnaround 10 and data[15:0].
- R6: A read drives 46 bits in total. After the preamble come start 01, opcode 10, PHY address[4:0] and register address[4:0], and then `mdio_oe` drops.
- R7: After the last driven bit, the line stays driven for one more low half-period. `mdio_oe` therefore falls 2*DIV cycles after the last driven rising edge, and one tristated `mdc` period follows.
- R8: On a read, `mdio_i` is sampled at the end of the high phase of the tristated turnaround period. A low level sets `ack_ok`.
- R9: Read data is 16 bits, MSB first, each sampled at the end of the `mdc` high phase. One further tristated `mdc` period follows the data.
- R10: A read without acknowledge returns `rdata` = 16'hFFFF with `ack_ok` low.
- R11: `done` is a one-cycle pulse with `busy` low. It comes 131*DIV cycles after the accepting edge for a write and 129*DIV for a read. A write reports `ack_ok` low and leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a transaction (taken when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 16 | Read result (16'hFFFF on no acknowledge) |
| ack_ok | output | 1 | Read acknowledged by the PHY, valid with done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Every result is tied to the edge that accepts the request:
- The first `mdc` rise is due DIV cycles after that edge.
- `mdio_oe` falls 2*DIV cycles after the last driven rise.
- `done` is due exactly 131*DIV cycles after it for a write and 129*DIV for a read.

The bench counts falling system-clock edges from the accepting edge until `done`, and compares the count with these figures. It timestamps `mdc` and `mdio_oe` transitions in units of the clock period. The PHY model changes `mdio_i` on each `mdc` rise, a full high phase before the block samples it. Read results are compared only in the `done` cycle.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        ack_ok,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CMAX = CW'(DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_TAIL, S_TA, S_DATA, S_END} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        ph;
  logic [6:0]  nleft;
  logic [63:0] sh;
  logic [15:0] rd;
  logic        ack;
  logic        is_wr;

  assign busy    = (st != S_IDLE);
  assign mdc     = ph;
  assign mdio_oe = (st == S_CMD) || (st == S_TAIL);
  assign mdio_o  = mdio_oe & sh[63];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ph     <= 1'b0;
      nleft  <= '0;
      sh     <= '0;
      rd     <= '0;
      ack    <= 1'b0;
      is_wr  <= 1'b0;
      done   <= 1'b0;
      ack_ok <= 1'b0;
      rdata  <= 16'hFFFF;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (req) begin
          st    <= S_CMD;
          cnt   <= '0;
          ph    <= 1'b0;
          is_wr <= wr;
          nleft <= wr ? 7'd64 : 7'd46;
          sh    <= wr ? {32'hFFFF_FFFF, 2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wdata}
                      : {32'hFFFF_FFFF, 2'b01, 2'b10, phy_addr, reg_addr, 18'h0};
        end
      end else if (cnt != CMAX) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          S_CMD:
            if (!ph) ph <= 1'b1;
            else begin
              ph <= 1'b0;
              sh <= {sh[62:0], 1'b0};
              if (nleft == 7'd1) st <= S_TAIL;
              else nleft <= nleft - 1'b1;
            end
          S_TAIL: st <= S_TA;
          S_TA:
            if (!ph) ph <= 1'b1;
            else begin
              ph <= 1'b0;
              if (is_wr) begin
                st     <= S_IDLE;
                done   <= 1'b1;
                ack_ok <= 1'b0;
              end else begin
                ack   <= ~mdio_i;
                st    <= S_DATA;
                nleft <= 7'd16;
              end
            end
          S_DATA:
            if (!ph) ph <= 1'b1;
            else begin
              ph <= 1'b0;
              rd <= {rd[14:0], mdio_i};
              if (nleft == 7'd1) st <= S_END;
              else nleft <= nleft - 1'b1;
            end
          S_END:
            if (!ph) ph <= 1'b1;
            else begin
              ph     <= 1'b0;
              st     <= S_IDLE;
              done   <= 1'b1;
              ack_ok <= ack;
              rdata  <= ack ? rd : 16'hFFFF;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        ack_ok,
  input logic [15:0] rdata,
  input logic        is_wr
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
  assert_start_on_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));
  assert_busy_ends_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_nack_all_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_wr && !ack_ok) |-> (rdata == 16'hFFFF));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done || is_wr) |-> $stable(rdata));
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done), .mdc(mdc),
  .mdio_oe(mdio_oe), .ack_ok(ack_ok), .rdata(rdata), .is_wr(is_wr)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  localparam int P   = 10;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wdata = '0;
  logic busy, done, ack_ok, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;
  logic mdio_i = 1'b1;

  always #(P/2) clk = ~clk;

  mdio_master #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wdata(wdata), .busy(busy), .done(done),
    .rdata(rdata), .ack_ok(ack_ok), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int nchk = 0, nerr = 0;
  int nrise, ndrv, nb;
  logic [63:0] cap;
  logic ack_en;
  logic [15:0] phy_dat;
  time t_acc, t_r1, t_r2, t_last, t_oefall;

  always @(posedge mdc) begin
    nrise++;
    if (nrise == 1) t_r1 = $time;
    if (nrise == 2) t_r2 = $time;
    if (mdio_oe) begin
      cap = {cap[62:0], mdio_o};
      ndrv++;
      t_last = $time;
    end
    if (nrise == nb + 1) mdio_i = ~ack_en;
    else if (nrise >= nb + 2 && nrise <= nb + 17) mdio_i = phy_dat[15 - (nrise - nb - 2)];
    else mdio_i = 1'b1;
  end

  always @(negedge mdio_oe) t_oefall = $time;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input bit w, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] wd, input bit ae, input logic [15:0] pd, input bit inject);
    logic [63:0] expf;
    logic [15:0] prev;
    int n;
    nb = w ? 64 : 46;
    nrise = 0; ndrv = 0; cap = '0; ack_en = ae; phy_dat = pd;
    prev = rdata;
    expf = w ? {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd}
             : {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
    @(negedge clk);
    req = 1'b1; wr = w; phy_addr = pa; reg_addr = ra; wdata = wd;
    @(posedge clk);
    t_acc = $time;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (inject && n == 40) begin
        req = 1'b1; wr = ~w; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
      end
      if (inject && n == 45) req = 1'b0;
    end
    chk(n == (w ? 131 : 129) * DIV, "R11 done latency", 64'(n), 64'((w ? 131 : 129) * DIV));
    chk(!busy, "R11 busy low with done", 64'(busy), 64'd0);
    chk(t_r1 - t_acc == DIV * P, "R3 first rise delay", 64'(t_r1 - t_acc), 64'(DIV * P));
    chk(t_r2 - t_r1 == 2 * DIV * P, "R3 mdc period", 64'(t_r2 - t_r1), 64'(2 * DIV * P));
    chk(ndrv == nb, w ? "R5 driven bit count" : "R6 driven bit count", 64'(ndrv), 64'(nb));
    if (w) begin
      chk(cap[63:32] == 32'hFFFF_FFFF, "R4 preamble", 64'(cap[63:32]), 64'hFFFF_FFFF);
      chk(cap == expf, "R5 write frame", cap, expf);
      chk(ack_ok == 1'b0, "R11 write ack_ok", 64'(ack_ok), 64'd0);
      chk(rdata == prev, "R11 write keeps rdata", 64'(rdata), 64'(prev));
    end else begin
      chk(cap[45:14] == 32'hFFFF_FFFF, "R4 preamble", 64'(cap[45:14]), 64'hFFFF_FFFF);
      chk(cap[45:0] == expf[45:0], "R6 read frame", 64'(cap[45:0]), 64'(expf[45:0]));
      chk(ack_ok == ae, "R8 ack_ok", 64'(ack_ok), 64'(ae));
      if (ae) chk(rdata == pd, "R9 read data", 64'(rdata), 64'(pd));
      else    chk(rdata == 16'hFFFF, "R10 no-ack value", 64'(rdata), 64'hFFFF);
    end
    chk(t_oefall - t_last == 2 * DIV * P, "R7 tail then release", 64'(t_oefall - t_last), 64'(2 * DIV * P));
    repeat (3) @(negedge clk);
    chk(!busy && !mdc && !mdio_oe, "R2 no restart after done", 64'({busy, mdc, mdio_oe}), 64'd0);
  endtask

  initial begin
    #(P * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, mdc, mdio_oe} == 4'b0, "R1 reset outputs", 64'({busy, done, mdc, mdio_oe}), 64'd0);
    chk(rdata == 16'hFFFF, "R1 reset rdata", 64'(rdata), 64'hFFFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, mdc, mdio_oe} == 4'b0, "R1 idle outputs", 64'({busy, done, mdc, mdio_oe}), 64'd0);
    for (int p = 0; p < 32; p++) begin
      run(1'b1, 5'(p), 5'(31 - p), 16'(p * 16'h0841) ^ 16'hA5C3, 1'b1, 16'h0, p == 5);
      run(1'b0, 5'(p), 5'(p), 16'h0, 1'b1, ~16'(p * 16'h1111) ^ 16'(p), p == 9);
    end
    for (int p = 0; p < 4; p++) begin
      run(1'b0, 5'(p * 7), 5'(p * 3), 16'h0, 1'b0, 16'(p * 16'h1234), 1'b0);
      run(1'b0, 5'(p * 5), 5'(p), 16'h0, 1'b1, 16'(p * 16'h4321 + 1), 1'b0);
    end
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule